// File: doc/BRIEF.md
# Serial Register Access Master

This block lets on-chip logic read or write one 8-bit register of an external USB host controller over a full-duplex, bit-serial link. A requester offers a 5-bit register number, a direction flag and a write byte on a valid/ready request port. The block then runs one framed two-byte exchange on the serial pins. Chip select is active low. The block shifts out a command byte and then a data byte. On every bit it samples the controller's serial output. When the exchange is over, it returns both captured bytes together with a one-cycle completion strobe.

The request port follows valid/ready rules. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a requester that raises `req_valid` during an access must hold its request fields steady until `req_ready` returns. The response side has no back-pressure. `rsp_valid` is high for exactly one cycle, and the requester must take `rsp_status` and `rsp_rdata` in that cycle, or later, because they hold until the next completion. The parameter `HALF_DIV` sets the serial clock speed as the number of system clocks in each half period of SCLK, and its minimum is 1.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `req_ready` is 1. These idle levels hold whenever the block is not busy.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` is 1 and `req_ready` is 0, and a request held during that time starts no new frame until the block is idle again.
- R3: Each access drives exactly 16 rising edges of `sclk`, all inside one low period of `ss_n`, and `sclk` is never 1 while `ss_n` is 1.
- R4: The first byte on `mosi` is the command byte. Bits 7:3 carry the register number, bit 1 is 1 for a write and 0 for a read, and bits 2 and 0 are 0.
- R5: Bits go out most significant first. `mosi` changes only while `sclk` is 0. The block samples `miso` at the end of each `sclk` high phase.
- R6: The second byte on `mosi` is `req_wdata` for a write and 0x00 for a read.
- R7: `rsp_status` is the byte received on `miso` during the command byte, for reads and writes alike.
- R8: `rsp_rdata` is the byte received on `miso` during the second byte.
- R9: `rsp_valid` is a single-cycle pulse that ends each access. `busy` is 0 in the cycle where `rsp_valid` is 1.
- R10: Each `sclk` high phase lasts exactly `HALF_DIV` system clocks, and so does each low phase inside a frame.
- R11: After the last falling edge of `sclk`, `ss_n` stays low for at least `HALF_DIV` clocks. Between two accesses it stays high for at least `HALF_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 5 | Register number |
| req_wdata | input | 8 | Byte to write (ignored for reads) |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_status | output | 8 | Byte captured during the command byte |
| rsp_rdata | output | 8 | Byte captured during the second byte |
| busy | output | 1 | Access in progress |
| ss_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |

## Verification
If the bit counter or the sequencer state goes wrong, the error shows on the pins within a single frame. The rising edges counted under one chip-select window no longer come to sixteen, or the trailing and gap intervals get shorter than `HALF_DIV`. A fault in the divider shows up at the first falling edge of `sclk`, as a high phase of the wrong length. A shift register that is corrupt or loaded in the wrong order shows up at the end of the frame: the command or data byte seen on `mosi` is wrong, or `rsp_status` and `rsp_rdata` differ from what the controller model returned, and the scoreboard flags it as soon as `rsp_valid` rises.

// File: rtl/spi_regm_pkg.sv
package spi_regm_pkg;

  localparam int unsigned REG_NUM_W = 5;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FRAME_W   = 2 * BYTE_W;

  typedef enum logic [2:0] {
    XS_IDLE  = 3'd0,
    XS_LOW   = 3'd1,
    XS_HIGH  = 3'd2,
    XS_TRAIL = 3'd3,
    XS_GAP   = 3'd4
  } xfer_state_e;

  // Command byte: register number in the upper five bits, direction at bit 1.
  function automatic logic [BYTE_W-1:0] build_cmd(input logic [REG_NUM_W-1:0] regnum,
                                                  input logic                 is_write);
    return {regnum, 1'b0, is_write, 1'b0};
  endfunction

endpackage

// File: rtl/spi_regm_halfclk.sv
module spi_regm_halfclk #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);

      // R10: a tick always restarts the half-period count
      p_restart_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
    end
  endgenerate

endmodule

// File: rtl/spi_regm_shifter.sv
module spi_regm_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               step,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_word
);

  logic [FRAME_W-1:0] tx_sr;
  logic [FRAME_W-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_word;
      rx_sr <= '0;
    end else if (step) begin
      tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
      rx_sr <= {rx_sr[FRAME_W-2:0], miso};
    end
  end

  assign mosi    = tx_sr[FRAME_W-1];
  assign rx_word = rx_sr;

  // R5: the most significant bit of a freshly loaded frame is presented first
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mosi == $past(load_word[FRAME_W-1])));

  // R8: each step captures the current serial input into the low bit
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (rx_word[0] == $past(miso)));

endmodule

// File: rtl/spi_regm_seq.sv
module spi_regm_seq
  import spi_regm_pkg::*;
#(
  parameter int unsigned FRAME_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic run,
  output logic ss_n,
  output logic sclk,
  output logic step,
  output logic finish
);

  localparam int unsigned BCW = $clog2(FRAME_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

  xfer_state_e state;
  logic [BCW-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      bit_idx <= '0;
      ss_n    <= 1'b1;
      sclk    <= 1'b0;
    end else begin
      unique case (state)
        XS_IDLE: if (start) begin
          state   <= XS_LOW;
          bit_idx <= '0;
          ss_n    <= 1'b0;
        end
        XS_LOW: if (tick) begin
          state <= XS_HIGH;
          sclk  <= 1'b1;
        end
        XS_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bit_idx == LAST_BIT) begin
            state <= XS_TRAIL;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            state   <= XS_LOW;
          end
        end
        XS_TRAIL: if (tick) begin
          state <= XS_GAP;
          ss_n  <= 1'b1;
        end
        XS_GAP: if (tick) begin
          state <= XS_IDLE;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign run    = (state != XS_IDLE);
  assign step   = (state == XS_HIGH) && tick;
  assign finish = (state == XS_GAP) && tick;

  // R3: the serial clock only rises inside a select window
  p_sclk_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);

  // R1: idle means select released and clock low
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XS_IDLE) |-> (ss_n && !sclk));

  // R11: select is released only from the trailing phase, with the clock low
  p_release_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (!sclk && $past(state == XS_TRAIL)));

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_regm_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [REG_NUM_W-1:0] req_addr,
  input  logic [BYTE_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [BYTE_W-1:0]    rsp_status,
  output logic [BYTE_W-1:0]    rsp_rdata,
  output logic                 busy,
  output logic                 ss_n,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso
);

  logic               run;
  logic               tick;
  logic               step;
  logic               finish;
  logic               start;
  logic [FRAME_W-1:0] load_word;
  logic [FRAME_W-1:0] rx_word;

  assign busy      = run;
  assign req_ready = !run;
  assign start     = req_valid && req_ready;
  assign load_word = {build_cmd(req_addr, req_write),
                      (req_write ? req_wdata : {BYTE_W{1'b0}})};

  spi_regm_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  spi_regm_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tick   (tick),
    .run    (run),
    .ss_n   (ss_n),
    .sclk   (sclk),
    .step   (step),
    .finish (finish)
  );

  spi_regm_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_word (load_word),
    .step      (step),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish) begin
        rsp_status <= rx_word[FRAME_W-1:BYTE_W];
        rsp_rdata  <= rx_word[BYTE_W-1:0];
      end
    end
  end

  // R2: an accepted request makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !req_ready));

  // R9: completion strobe lasts one cycle and coincides with idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  // R5: data out holds while the serial clock stays high
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R1: data out rests low whenever no access is running
  p_idle_mosi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mosi && ss_n && !sclk));

endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_status;
  logic [7:0] rsp_rdata;
  logic       busy;
  logic       ss_n;
  logic       sclk;
  logic       mosi;
  logic       miso = 1'b0;

  spi_reg_master #(.HALF_DIV(HALF)) i_spi_reg_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .busy(busy), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] exp_rsp_q[$];
  logic [15:0] exp_mosi_q[$];
  logic [15:0] reply_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Controller model and pin monitor, sampled on the falling system clock edge
  logic        prev_ss = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_rsp = 1'b0;
  logic [15:0] cur_reply = '0, cap = '0;
  int          bit_pos = 0, rises = 0, hi_len = 0, since_fall = 0, gap_len = 0;
  int          mosi_hi_changes = 0;
  bit          had_frame = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && prev_sclk && (mosi != prev_mosi)) mosi_hi_changes++;
      if (ss_n) gap_len++;
      if (sclk) hi_len++;
      if (!sclk) since_fall++;
      if (!ss_n && prev_ss) begin
        if (had_frame) check(gap_len >= HALF, "R11", "select high gap", 16'(gap_len), 16'(HALF));
        cur_reply = (reply_q.size() > 0) ? reply_q.pop_front() : 16'h0000;
        miso <= cur_reply[15];
        bit_pos = 14;
        rises = 0;
        cap = '0;
      end
      if (sclk && !prev_sclk) begin
        cap = {cap[14:0], mosi};
        rises++;
      end
      if (!sclk && prev_sclk) begin
        check(hi_len == HALF, "R10", "sclk high length", 16'(hi_len), 16'(HALF));
        hi_len = 0;
        since_fall = 0;
        miso <= (bit_pos >= 0) ? cur_reply[bit_pos] : 1'b0;
        bit_pos--;
      end
      if (ss_n && !prev_ss) begin
        logic [15:0] e;
        e = (exp_mosi_q.size() > 0) ? exp_mosi_q.pop_front() : 16'hxxxx;
        check(rises == 16, "R3", "sclk rises per frame", 16'(rises), 16'd16);
        check(cap[15:8] === e[15:8], "R4", "command byte", {8'h00, cap[15:8]}, {8'h00, e[15:8]});
        check(cap[7:0] === e[7:0], "R6", "second byte", {8'h00, cap[7:0]}, {8'h00, e[7:0]});
        check(since_fall >= HALF, "R11", "trail before release", 16'(since_fall), 16'(HALF));
        gap_len = 1;
        had_frame = 1'b1;
      end
      if (prev_rsp) check(!rsp_valid, "R9", "strobe width", {15'd0, rsp_valid}, 16'd0);
      if (rsp_valid) begin
        logic [15:0] r;
        r = (exp_rsp_q.size() > 0) ? exp_rsp_q.pop_front() : 16'hxxxx;
        check(rsp_status === r[15:8], "R7", "status byte", {8'h00, rsp_status}, {8'h00, r[15:8]});
        check(rsp_rdata === r[7:0], "R8", "read byte", {8'h00, rsp_rdata}, {8'h00, r[7:0]});
        check(!busy, "R9", "busy at strobe", {15'd0, busy}, 16'd0);
      end
      prev_ss   = ss_n;
      prev_sclk = sclk;
      prev_mosi = mosi;
      prev_rsp  = rsp_valid;
    end
  end

  // Driver: pushes expectations, then offers the request under valid/ready
  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] d,
                        input logic [15:0] reply);
    exp_mosi_q.push_back({a, 1'b0, wr, 1'b0, (wr ? d : 8'h00)});
    reply_q.push_back(reply);
    exp_rsp_q.push_back(reply);
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 8'h3C;
    check(busy && !req_ready, "R2", "busy after accept", {14'd0, busy, req_ready}, 16'h0002);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(ss_n && !sclk && !mosi && !busy && req_ready, "R1", "reset pins",
          {11'd0, ss_n, sclk, mosi, busy, req_ready}, 16'h0011);
    rst_n = 1'b1;
    @(negedge clk);
    check(ss_n && !sclk && !mosi && req_ready, "R1", "idle after reset",
          {12'd0, ss_n, sclk, mosi, req_ready}, 16'h0009);

    access(1'b0, 5'd18, 8'hFF, 16'h8113);   // read: wdata ignored, 0x00 sent
    access(1'b1, 5'd17, 8'h18, 16'h40AA);   // back-to-back write, held while busy
    access(1'b1, 5'd31, 8'hA5, 16'hFF00);
    access(1'b0, 5'd0,  8'h77, 16'h00FF);
    access(1'b1, 5'd13, 8'h00, 16'h5A5A);
    access(1'b0, 5'd25, 8'h00, 16'hC37E);

    while (busy || exp_rsp_q.size() > 0) @(negedge clk);
    repeat (2 * HALF) @(negedge clk);
    check(ss_n && !sclk && !mosi && req_ready, "R1", "idle at end",
          {12'd0, ss_n, sclk, mosi, req_ready}, 16'h0009);
    check(mosi_hi_changes == 0, "R5", "mosi moved during sclk high", 16'(mosi_hi_changes), 16'd0);
    check(exp_mosi_q.size() == 0, "R3", "frames left unseen", 16'(exp_mosi_q.size()), 16'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule